// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block forms the register result of a partial-word load that straddles a word boundary. Two load flavours exist. The "left" flavour fills the upper bytes of the target register from memory. The "right" flavour fills the lower bytes. The caller reads one aligned word from memory, at the effective address with its low offset bits cleared. It then presents that word together with the effective address, the target register index, the register file's current value of that register, and the delayed-load entry that is retiring in the same cycle.

The byte offset inside the word decides how many bytes come from memory and how many bytes keep the old register value. If the retiring delayed load writes the same register, the old value is taken from that entry and not from the register file. Without this, a second partial load that follows the first straight away would merge into a stale value. The merged word is registered and handed on, one cycle later, to the delayed-load path together with the target index. It is never written to the register file at once.

Top module: `unaligned_merge`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, `out_rd` is 0 and `out_data` is 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 in the cycle after a cycle with `req_valid` = 0. `out_rd` then equals the `req_rd` of that request.
- R3: Left flavour (`req_right` = 0), with offset k = `req_addr[1:0]`: the result is the old value ANDed with 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0x00000000 for k = 0, 1, 2, 3, ORed with `mem_word` shifted left by 24, 16, 8 or 0 bits.
- R4: Right flavour (`req_right` = 1): the result is the old value ANDed with 0x00000000, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 for k = 0, 1, 2, 3, ORed with `mem_word` shifted right by 0, 8, 16 or 24 bits.
- R5: Only `req_addr[1:0]` affects the result. The address bits above them have no effect.
- R6: When `pend_valid` = 1 and `pend_rd` equals `req_rd`, the old value is `pend_data` and not `rf_data`.
- R7: When `pend_valid` = 0, or when `pend_rd` differs from `req_rd`, the old value is `rf_data`.
- R8: A request with `req_rd` = 0 yields `out_data` = 0, whatever the merge and forward inputs are.
- R9: In a cycle after a cycle with no request, `out_rd` and `out_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A merge request is present |
| req_right | input | 1 | 0 = left flavour, 1 = right flavour |
| req_addr | input | ADDR_W | Effective byte address of the load |
| req_rd | input | REG_AW | Target register index |
| mem_word | input | DATA_W | Word read at the aligned address |
| rf_data | input | DATA_W | Register file value of the target |
| pend_valid | input | 1 | A delayed-load entry retires this cycle |
| pend_rd | input | REG_AW | Register written by the retiring entry |
| pend_data | input | DATA_W | Value carried by the retiring entry |
| out_valid | output | 1 | Merged result is present |
| out_rd | output | REG_AW | Target register of the merged result |
| out_data | output | DATA_W | Merged word for the delayed-load path |

## Verification
Forwarding from the retiring delayed-load entry can fall in the same cycle as the register-zero suppression. It can also fall in the same cycle as the offset cases that keep no old bytes. The bench provokes both by aiming a pending entry at the request's own target, including index 0. It does this at offsets where the forwarded bytes are fully visible and at offsets where they are fully replaced. A reference model built from masks and shifts predicts every cycle's outputs. The bench judges forwarding by bytes of `pend_data` that must appear in the result and bytes of `rf_data` that must not.

// File: rtl/unaligned_merge.sv
module unaligned_merge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_right,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_AW-1:0] req_rd,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              pend_valid,
  input  logic [REG_AW-1:0] pend_rd,
  input  logic [DATA_W-1:0] pend_data,
  output logic              out_valid,
  output logic [REG_AW-1:0] out_rd,
  output logic [DATA_W-1:0] out_data
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] merged;
  logic              fwd_hit;
  logic              unused_hi;

  assign off       = req_addr[OFF_W-1:0];
  assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];
  assign fwd_hit   = pend_valid && (pend_rd == req_rd);
  assign old_val   = fwd_hit ? pend_data : rf_data;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lft [BYTES];
    logic [7:0] rgt [BYTES];
    for (genvar o = 0; o < BYTES; o++) begin : g_off
      if (b >= BYTES - 1 - o) begin : g_lm
        assign lft[o] = mem_word[(b - (BYTES - 1 - o))*8 +: 8];
      end else begin : g_lo
        assign lft[o] = old_val[b*8 +: 8];
      end
      if (b + o <= BYTES - 1) begin : g_rm
        assign rgt[o] = mem_word[(b + o)*8 +: 8];
      end else begin : g_ro
        assign rgt[o] = old_val[b*8 +: 8];
      end
    end
    assign merged[b*8 +: 8] = req_right ? rgt[off] : lft[off];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rd    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_rd   <= req_rd;
        out_data <= (req_rd == '0) ? '0 : merged;
      end
    end
  end

endmodule

module unaligned_merge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_right,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_AW-1:0] req_rd,
  input logic [DATA_W-1:0] mem_word,
  input logic [DATA_W-1:0] rf_data,
  input logic              pend_valid,
  input logic [REG_AW-1:0] pend_rd,
  input logic [DATA_W-1:0] pend_data,
  input logic              out_valid,
  input logic [REG_AW-1:0] out_rd,
  input logic [DATA_W-1:0] out_data
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  a_r2_rd_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_rd == $past(req_rd));
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rd == '0) |-> out_data == '0);
  a_r3_left_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_right && req_addr[1:0] == 2'd3 && req_rd != '0)
      |=> out_data == $past(mem_word));
  a_r4_right_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_right && req_addr[1:0] == 2'd0 && req_rd != '0)
      |=> out_data == $past(mem_word));
  a_r6_forward_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_right && req_addr[1:0] == 2'd0 && req_rd != '0
      && pend_valid && pend_rd == req_rd)
      |=> out_data[23:0] == $past(pend_data[23:0]));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_data) && $stable(out_rd)));

endmodule

bind unaligned_merge unaligned_merge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_chk (.*);

// File: tb/unaligned_merge_bench.sv
`timescale 1ns/1ps
module unaligned_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_right = 1'b0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_rd = '0;
  logic [31:0] mem_word = '0, rf_data = '0;
  logic        pend_valid = 1'b0;
  logic [4:0]  pend_rd = '0;
  logic [31:0] pend_data = '0;
  logic        out_valid;
  logic [4:0]  out_rd;
  logic [31:0] out_data;

  int checks = 0, errors = 0;
  logic        e_valid = 1'b0;
  logic [4:0]  e_rd = '0;
  logic [31:0] e_data = '0;
  string       cur_tag = "R1";

  always #2 clk = ~clk;

  unaligned_merge u_unaligned_merge (.*);

  function automatic logic [31:0] ref_merge(bit right, int k, logic [31:0] mem, logic [31:0] old);
    logic [31:0] keep;
    if (!right) begin
      keep = (k == 3) ? 32'h0 : (32'hFFFF_FFFF >> (8*(k+1)));
      return (old & keep) | (mem << (8*(3-k)));
    end
    keep = ~(32'hFFFF_FFFF >> (8*k));
    return (old & keep) | (mem >> (8*k));
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== e_valid || out_rd !== e_rd || out_data !== e_data) begin
      errors++;
      $display("FAIL %s: got v=%0b rd=%0d data=%08h, expected v=%0b rd=%0d data=%08h",
               cur_tag, out_valid, out_rd, out_data, e_valid, e_rd, e_data);
    end
  endtask

  task automatic step(string tag, bit v, bit right, logic [31:0] addr, logic [4:0] rd,
                      logic [31:0] mem, logic [31:0] rf, bit pv, logic [4:0] pr,
                      logic [31:0] pd);
    logic [31:0] old;
    @(negedge clk);
    compare();
    req_valid = v; req_right = right; req_addr = addr; req_rd = rd;
    mem_word = mem; rf_data = rf; pend_valid = pv; pend_rd = pr; pend_data = pd;
    old = (pv && pr == rd) ? pd : rf;
    e_valid = v;
    if (v) begin
      e_rd = rd;
      e_data = (rd == 0) ? 32'h0 : ref_merge(right, int'(addr[1:0]), mem, old);
    end
    cur_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R1 during reset
    rst_n = 1'b1;
    // R1 first cycle after reset
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 left, every offset
    for (int k = 0; k < 4; k++)
      step("R3", 1, 0, 32'h1000 + k, 5'd7, 32'h1122_3344, 32'hAABB_CCDD, 0, 0, 0);
    // R4 right, every offset
    for (int k = 0; k < 4; k++)
      step("R4", 1, 1, 32'h2000 + k, 5'd9, 32'h1122_3344, 32'hAABB_CCDD, 0, 0, 0);
    // R2 gaps and index pass-through, R9 hold
    step("R2", 0, 0, 0, 5'd3, 32'hFFFF_FFFF, 32'h0, 0, 0, 0);
    step("R9", 0, 1, 32'h3, 5'd4, 32'h0, 32'h1234_5678, 0, 0, 0);
    step("R2", 1, 0, 32'h2, 5'd31, 32'hCAFE_F00D, 32'h0BAD_0BAD, 0, 0, 0);
    // R5 upper address bits ignored
    step("R5", 1, 0, 32'hFFFF_FFF1, 5'd12, 32'h5566_7788, 32'h99AA_BBCC, 0, 0, 0);
    step("R5", 1, 1, 32'h8000_0002, 5'd12, 32'h5566_7788, 32'h99AA_BBCC, 0, 0, 0);
    // R6 forwarding from the retiring entry
    step("R6", 1, 0, 32'h0, 5'd8, 32'h0000_00EE, 32'h1111_1111, 1, 5'd8, 32'h00A1_B2C3);
    step("R6", 1, 1, 32'h3, 5'd8, 32'hDD00_0000, 32'h1111_1111, 1, 5'd8, 32'h77A1_B2C3);
    step("R6", 1, 0, 32'h3, 5'd8, 32'h4444_4444, 32'h1111_1111, 1, 5'd8, 32'h9999_9999);
    // R7 no forwarding: invalid entry, other register
    step("R7", 1, 0, 32'h1, 5'd8, 32'h0102_0304, 32'h1111_1111, 0, 5'd8, 32'h9999_9999);
    step("R7", 1, 1, 32'h2, 5'd8, 32'h0102_0304, 32'h1111_1111, 1, 5'd6, 32'h9999_9999);
    // R8 zero target, with and without forwarding
    step("R8", 1, 0, 32'h1, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    step("R8", 1, 1, 32'h0, 5'd0, 32'hFFFF_FFFF, 32'h0, 1, 5'd0, 32'h5A5A_5A5A);
    // back-to-back mixed patterns
    for (int i = 0; i < 200; i++) begin
      logic [4:0] rd = 5'($urandom_range(0, 31));
      step((i % 2) ? "R6" : "R3", bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
           $urandom, rd, $urandom, $urandom, bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)) ? rd : 5'($urandom_range(0, 31)), $urandom);
    end
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule